// File: doc/BRIEF.md
# CAN Receive Buffer Manager

This block sits between a CAN protocol engine and the host side of a CAN controller. While a frame is on the bus, the engine writes its identifier, format bits, length code and data into a background staging buffer. When the frame ends, the engine reports four things: whether the frame was error-free, whether the identifier filter accepted it, which filter matched, and the node's transmit situation. The transmit situation is made up of three inputs: own transmission, arbitration lost and loopback. From these inputs the block decides whether the staged frame moves into a four-slot receive FIFO.

Own frames are staged but not kept in normal operation. They are kept when loopback is on or when arbitration was lost. When every slot is occupied, a further qualifying frame is thrown away and a sticky overrun flag is set. The host reads the oldest slot directly from the head outputs. It frees that slot with a one-cycle release pulse, and after that the FIFO takes new frames again.

Top module: `can_rx_bufmgr`

## Requirements
- R1: After reset the FIFO is empty (count 0, receive-full low), the overrun flag is clear and both interrupt outputs are low.
- R2: A frame with `frm_done_i`, `frm_ok_i` and `id_hit_i` all high is stored in a free slot on that clock edge. The count and receive-full outputs reflect it from the next cycle. The stored slot holds the staged identifier, format bits, length code and data, together with `hit_idx_i` sampled at completion.
- R3: A frame that completes with `frm_ok_i` low or `id_hit_i` low is not stored. The next `stg_load_i` overwrites the staging buffer.
- R4: A frame that completes with `own_tx_i` high and both `loopback_i` and `arb_lost_i` low is not stored. `ack_en_o` is low whenever that input combination is present.
- R5: With `loopback_i` high, an own frame that is valid and accepted is stored like any other frame.
- R6: With `arb_lost_i` high, a frame that is valid and accepted is stored even though `own_tx_i` is high.
- R7: The FIFO holds at most 4 frames. The head outputs always show the oldest stored frame, and frames leave in arrival order.
- R8: A qualifying frame that completes while all 4 slots are full, with no release in the same cycle, is discarded. The overrun flag is set and stays set until an `ovr_clr_i` pulse. `ovr_irq_o` equals the flag ANDed with `ovr_ie_i`.
- R9: After a slot is released following an overrun, the next qualifying frame is stored.
- R10: A store and a release in the same cycle leave the count unchanged. The released frame leaves and the new frame enters. With a full FIFO in that cycle, no overrun occurs.
- R11: `rx_full_o` is high exactly when the count is non-zero. `rx_irq_o` equals `rx_full_o` ANDed with `rx_ie_i`.
- R12: A release pulse while the FIFO is empty has no effect. The next stored frame appears correctly at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_load_i | input | 1 | Write the frame fields into the staging buffer |
| stg_id_i | input | 29 | Identifier (standard identifiers use the low 11 bits) |
| stg_ide_i | input | 1 | Extended-format flag |
| stg_rtr_i | input | 1 | Remote-request flag |
| stg_dlc_i | input | 4 | Data length code |
| stg_data_i | input | 64 | Data bytes, byte 0 in bits 7:0 |
| frm_done_i | input | 1 | One-cycle pulse at the end of a frame |
| frm_ok_i | input | 1 | Frame received without error |
| id_hit_i | input | 1 | Identifier accepted by the filter |
| hit_idx_i | input | 3 | Index of the matching filter |
| own_tx_i | input | 1 | Node is transmitting this frame |
| arb_lost_i | input | 1 | Node lost arbitration for this frame |
| loopback_i | input | 1 | Loopback mode |
| rel_i | input | 1 | Host releases the head slot |
| ovr_clr_i | input | 1 | Host clears the overrun flag |
| rx_ie_i | input | 1 | Receive interrupt enable |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| ack_en_o | output | 1 | Node may acknowledge the current frame |
| rx_full_o | output | 1 | FIFO holds at least one frame |
| rx_irq_o | output | 1 | Receive interrupt |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| ovr_irq_o | output | 1 | Overrun interrupt |
| rx_count_o | output | 3 | Frames in the FIFO |
| head_id_o | output | 29 | Head frame identifier |
| head_ide_o | output | 1 | Head frame extended flag |
| head_rtr_o | output | 1 | Head frame remote flag |
| head_dlc_o | output | 4 | Head frame length code |
| head_data_o | output | 64 | Head frame data |
| head_hit_o | output | 3 | Head frame filter index |

## Verification
A corrupted read or write pointer shows up at the head outputs. The frame released next then differs from the expected oldest frame, which is visible one cycle after the release edge. A miscounted occupancy shows on `rx_count_o` and `rx_full_o` in the cycle after the faulty commit or release. It also appears later as an overrun that comes too early or too late, at the fifth qualifying frame. An error in the drop rule for own frames shows as a changed count in the cycle after completion.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int HIT_W  = 3;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    typedef struct packed {
        rx_frame_t         frm;
        logic [HIT_W-1:0]  hit;
    } rx_slot_t;
endpackage

// File: rtl/can_rx_stage.sv
module can_rx_stage
    import can_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  rx_frame_t frm_i,
    output rx_frame_t frm_o
);
    typedef struct packed {
        rx_frame_t frm;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.frm = frm_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_o = st_q.frm;

    // R3: a load always replaces the staged content on the next cycle
    assert_stage_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (frm_o == $past(frm_i)));
endmodule

// File: rtl/can_rx_commit.sv
module can_rx_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic ok_i,
    input  logic accept_i,
    input  logic own_i,
    input  logic arb_i,
    input  logic lb_i,
    input  logic full_i,
    input  logic empty_i,
    input  logic rel_i,
    input  logic clr_i,
    output logic commit_o,
    output logic ovr_o,
    output logic ack_en_o
);
    typedef struct packed {
        logic ovr;
    } cst_t;

    cst_t cs_d, cs_q;
    logic own_kept;
    logic eligible;
    logic room;
    logic ovr_set;

    always_comb begin
        own_kept = !own_i || lb_i || arb_i;
        eligible = ok_i && accept_i && own_kept;
        room     = !full_i || (rel_i && !empty_i);
        commit_o = done_i && eligible && room;
        ovr_set  = done_i && eligible && !room;
        ack_en_o = own_kept;

        cs_d = cs_q;
        if (ovr_set) begin
            cs_d.ovr = 1'b1;
        end else if (clr_i) begin
            cs_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ovr_o = cs_q.ovr;

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !clr_i) |=> ovr_o);

    assert_ovr_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ok_i && accept_i && !own_i && full_i && !rel_i) |=> ovr_o);

    assert_own_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_i && !lb_i && !arb_i) |-> (!commit_o && !ack_en_o));
endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
    import can_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  rx_slot_t                      wdata_i,
    input  logic                          rel_i,
    output rx_slot_t                      head_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          full_o,
    output logic                          empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fctl_t;

    fctl_t    fc_d, fc_q;
    rx_slot_t slot_q [DEPTH];
    logic     pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fc_d = fc_q;
        pop  = rel_i && (fc_q.count != '0);
        if (wr_i) begin
            fc_d.wr_ptr = ptr_next(fc_q.wr_ptr);
        end
        if (pop) begin
            fc_d.rd_ptr = ptr_next(fc_q.rd_ptr);
        end
        case ({wr_i, pop})
            2'b10:   fc_d.count = fc_q.count + 1'b1;
            2'b01:   fc_d.count = fc_q.count - 1'b1;
            default: fc_d.count = fc_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_q <= '0;
        end else begin
            fc_q <= fc_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (wr_i && (fc_q.wr_ptr == PTR_W'(i))) begin
                slot_q[i] <= wdata_i;
            end
        end
    end

    assign head_o  = slot_q[fc_q.rd_ptr];
    assign count_o = fc_q.count;
    assign full_o  = (fc_q.count == CNT_W'(DEPTH));
    assign empty_o = (fc_q.count == '0);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));

    assert_write_has_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (!full_o || rel_i));

    assert_swap_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && rel_i && !empty_o) |=> $stable(count_o));

    assert_empty_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !wr_i && empty_o) |=> empty_o);
endmodule

// File: rtl/can_rx_bufmgr.sv
module can_rx_bufmgr
    import can_rx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stg_load_i,
    input  logic [ID_W-1:0]      stg_id_i,
    input  logic                 stg_ide_i,
    input  logic                 stg_rtr_i,
    input  logic [DLC_W-1:0]     stg_dlc_i,
    input  logic [DATA_W-1:0]    stg_data_i,
    input  logic                 frm_done_i,
    input  logic                 frm_ok_i,
    input  logic                 id_hit_i,
    input  logic [HIT_W-1:0]     hit_idx_i,
    input  logic                 own_tx_i,
    input  logic                 arb_lost_i,
    input  logic                 loopback_i,
    input  logic                 rel_i,
    input  logic                 ovr_clr_i,
    input  logic                 rx_ie_i,
    input  logic                 ovr_ie_i,
    output logic                 ack_en_o,
    output logic                 rx_full_o,
    output logic                 rx_irq_o,
    output logic                 ovr_flag_o,
    output logic                 ovr_irq_o,
    output logic [CNT_W-1:0]     rx_count_o,
    output logic [ID_W-1:0]      head_id_o,
    output logic                 head_ide_o,
    output logic                 head_rtr_o,
    output logic [DLC_W-1:0]     head_dlc_o,
    output logic [DATA_W-1:0]    head_data_o,
    output logic [HIT_W-1:0]     head_hit_o
);
    rx_frame_t in_frm;
    rx_frame_t stg_frm;
    rx_slot_t  wslot;
    rx_slot_t  head;
    logic      commit;
    logic      f_full;
    logic      f_empty;

    always_comb begin
        in_frm.id   = stg_id_i;
        in_frm.ide  = stg_ide_i;
        in_frm.rtr  = stg_rtr_i;
        in_frm.dlc  = stg_dlc_i;
        in_frm.data = stg_data_i;
        wslot.frm   = stg_frm;
        wslot.hit   = hit_idx_i;
    end

    can_rx_stage u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (stg_load_i),
        .frm_i  (in_frm),
        .frm_o  (stg_frm)
    );

    can_rx_commit u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (frm_done_i),
        .ok_i     (frm_ok_i),
        .accept_i (id_hit_i),
        .own_i    (own_tx_i),
        .arb_i    (arb_lost_i),
        .lb_i     (loopback_i),
        .full_i   (f_full),
        .empty_i  (f_empty),
        .rel_i    (rel_i),
        .clr_i    (ovr_clr_i),
        .commit_o (commit),
        .ovr_o    (ovr_flag_o),
        .ack_en_o (ack_en_o)
    );

    can_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (commit),
        .wdata_i (wslot),
        .rel_i   (rel_i),
        .head_o  (head),
        .count_o (rx_count_o),
        .full_o  (f_full),
        .empty_o (f_empty)
    );

    assign rx_full_o   = !f_empty;
    assign rx_irq_o    = rx_full_o && rx_ie_i;
    assign ovr_irq_o   = ovr_flag_o && ovr_ie_i;
    assign head_id_o   = head.frm.id;
    assign head_ide_o  = head.frm.ide;
    assign head_rtr_o  = head.frm.rtr;
    assign head_dlc_o  = head.frm.dlc;
    assign head_data_o = head.frm.data;
    assign head_hit_o  = head.hit;

    assert_irq_needs_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> (rx_full_o && rx_count_o != '0));

    assert_commit_raises_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_full_o);
endmodule

// File: tb/sim_can_rx_bufmgr.sv
`timescale 1ns/1ps
module sim_can_rx_bufmgr;
    typedef struct packed {
        logic [28:0] id;
        logic        ide;
        logic [3:0]  dlc;
        logic [63:0] data;
        logic [2:0]  hit;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stg_load_i = 1'b0;
    logic [28:0] stg_id_i = '0;
    logic        stg_ide_i = 1'b0;
    logic        stg_rtr_i = 1'b0;
    logic [3:0]  stg_dlc_i = '0;
    logic [63:0] stg_data_i = '0;
    logic        frm_done_i = 1'b0;
    logic        frm_ok_i = 1'b0;
    logic        id_hit_i = 1'b0;
    logic [2:0]  hit_idx_i = '0;
    logic        own_tx_i = 1'b0;
    logic        arb_lost_i = 1'b0;
    logic        loopback_i = 1'b0;
    logic        rel_i = 1'b0;
    logic        ovr_clr_i = 1'b0;
    logic        rx_ie_i = 1'b0;
    logic        ovr_ie_i = 1'b0;
    logic        ack_en_o, rx_full_o, rx_irq_o, ovr_flag_o, ovr_irq_o;
    logic [2:0]  rx_count_o;
    logic [28:0] head_id_o;
    logic        head_ide_o, head_rtr_o;
    logic [3:0]  head_dlc_o;
    logic [63:0] head_data_o;
    logic [2:0]  head_hit_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    can_rx_bufmgr u0 (.*);

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic exp_t mk(input int k);
        exp_t e;
        e.id   = 29'h0ABC_0000 + 29'(k * 29'h1357);
        e.ide  = e.id[0];
        e.dlc  = 4'(k % 9);
        e.data = 64'h0123_4567_89AB_CDEF ^ {8{8'(k)}};
        e.hit  = 3'(k % 8);
        return e;
    endfunction

    // driver: stages a frame, completes it, and pushes the expectation
    task automatic send(input int k, input bit ok, input bit acc,
                        input bit own, input bit arb, input bit lb);
        exp_t e = mk(k);
        bit   keep = ok && acc && (!own || lb || arb);
        @(negedge clk);
        stg_load_i = 1'b1; stg_id_i = e.id; stg_ide_i = e.ide;
        stg_dlc_i = e.dlc; stg_data_i = e.data;
        @(negedge clk);
        stg_load_i = 1'b0;
        frm_done_i = 1'b1; frm_ok_i = ok; id_hit_i = acc; hit_idx_i = e.hit;
        own_tx_i = own; arb_lost_i = arb; loopback_i = lb;
        if (keep && sb.size() < 4) sb.push_back(e);
        @(negedge clk);
        frm_done_i = 1'b0; frm_ok_i = 1'b0; id_hit_i = 1'b0;
        own_tx_i = 1'b0; arb_lost_i = 1'b0; loopback_i = 1'b0;
    endtask

    // monitor: compares the head against the oldest expectation, then releases it
    task automatic pop_check(input string req);
        exp_t e = sb.pop_front();
        check({99'(0), rx_full_o}, 128'(1), req);
        check(128'({head_id_o, head_ide_o, head_dlc_o, head_data_o, head_hit_o}),
              128'(e), req);
        rel_i = 1'b1;
        @(negedge clk);
        rel_i = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(128'({rx_count_o, rx_full_o, ovr_flag_o, rx_irq_o, ovr_irq_o}), 128'(0), "R1");

        // R4 own frame: no acknowledge, not stored
        own_tx_i = 1'b1;
        #1 check(128'(ack_en_o), 128'(0), "R4 ack");
        own_tx_i = 1'b0;
        #1 check(128'(ack_en_o), 128'(1), "R4 ack foreign");
        send(1, 1, 1, 1, 0, 0);
        check(128'(rx_count_o), 128'(0), "R4 count");

        // R3 erroneous and rejected frames
        send(2, 0, 1, 0, 0, 0);
        send(3, 1, 0, 0, 0, 0);
        check(128'(rx_count_o), 128'(0), "R3 count");

        // R2 normal frame
        send(4, 1, 1, 0, 0, 0);
        check(128'({rx_count_o, rx_full_o}), 128'({3'd1, 1'b1}), "R2 count");
        // R5 loopback own, R6 arbitration lost
        send(5, 1, 1, 1, 0, 1);
        check(128'(rx_count_o), 128'(2), "R5 count");
        send(6, 1, 1, 1, 1, 0);
        check(128'(rx_count_o), 128'(3), "R6 count");
        send(7, 1, 1, 0, 0, 0);
        check(128'(rx_count_o), 128'(4), "R7 count");

        // R11 interrupt gating
        check(128'(rx_irq_o), 128'(0), "R11 disabled");
        rx_ie_i = 1'b1;
        #1 check(128'(rx_irq_o), 128'(1), "R11 enabled");

        // R8 overrun
        ovr_ie_i = 1'b1;
        send(8, 1, 1, 0, 0, 0);
        check(128'({rx_count_o, ovr_flag_o, ovr_irq_o}), 128'({3'd4, 1'b1, 1'b1}), "R8 overrun");
        ovr_ie_i = 1'b0;
        repeat (3) @(negedge clk);
        check(128'({ovr_flag_o, ovr_irq_o}), 128'({1'b1, 1'b0}), "R8 sticky");
        ovr_clr_i = 1'b1;
        @(negedge clk);
        ovr_clr_i = 1'b0;
        check(128'(ovr_flag_o), 128'(0), "R8 cleared");

        // R9 accepted again after a release
        pop_check("R2 head");
        send(9, 1, 1, 0, 0, 0);
        check(128'({rx_count_o, ovr_flag_o}), 128'({3'd4, 1'b0}), "R9 count");

        // R10 store and release in the same cycle while full
        begin
            exp_t e = mk(10);
            exp_t old;
            @(negedge clk);
            stg_load_i = 1'b1; stg_id_i = e.id; stg_ide_i = e.ide;
            stg_dlc_i = e.dlc; stg_data_i = e.data;
            @(negedge clk);
            stg_load_i = 1'b0;
            old = sb.pop_front();
            check(128'({head_id_o, head_ide_o, head_dlc_o, head_data_o, head_hit_o}),
                  128'(old), "R10 head");
            frm_done_i = 1'b1; frm_ok_i = 1'b1; id_hit_i = 1'b1; hit_idx_i = e.hit;
            rel_i = 1'b1;
            sb.push_back(e);
            @(negedge clk);
            frm_done_i = 1'b0; frm_ok_i = 1'b0; id_hit_i = 1'b0; rel_i = 1'b0;
            check(128'({rx_count_o, ovr_flag_o}), 128'({3'd4, 1'b0}), "R10 count");
        end

        // R7 drain in order
        for (int i = 0; i < 4; i++) pop_check("R7 order");
        check(128'({rx_count_o, rx_full_o, rx_irq_o}), 128'(0), "R11 empty");

        // R12 release while empty
        rel_i = 1'b1;
        @(negedge clk);
        rel_i = 1'b0;
        check(128'(rx_count_o), 128'(0), "R12 count");
        send(11, 1, 1, 0, 0, 0);
        send(12, 1, 1, 0, 0, 1);
        pop_check("R12 head");
        pop_check("R12 second");
        check(128'(rx_count_o), 128'(0), "R12 drained");

        summary();
    end
endmodule